// File: doc/BRIEF.md
# Unsigned Integer to Floating-Point Converter

This block turns an unsigned integer into an IEEE-754 binary floating-point value. Each request chooses a 32-bit or 64-bit source and a single- or double-precision result. The block locates the most significant set bit and shifts the value so that this bit becomes the hidden bit. It then forms the biased exponent and rounds the discarded low bits under a rounding mode given with the request.

A request is accepted in any cycle where `req_valid` is high, because the unit is always ready. One clock later the registered result appears together with a one-cycle `done` pulse. A conversion that loses precision reports this in one of two ways, chosen per request. With the trap enabled, the exception code says inexact. With the trap disabled, a sticky flag is set that stays high until reset. A single-precision result sits in the low half of the 64-bit result bus.

Top module: `uint_to_fp_conv`

## Requirements
- R1: An all-zero source produces +0 (all result bits zero) with exception code 00, and the sticky flag keeps its value. This holds for both source widths.
- R2: The stored exponent is the bit index of the source's most significant one plus 127 for single precision or 1023 for double precision. The sign bit is always 0.
- R3: The fraction field holds the source bits just below the leading one, taken from the top down. A 64-bit source whose upper word is zero converts correctly, with its leading-one index counted from bit 0 of the full 64-bit value.
- R4: A 32-bit source converted to double precision is always exact. It gives exception code 00 and never changes the sticky flag, whatever the rounding mode.
- R5: `rnd_mode` 00 selects round to nearest. On an exact tie it rounds to the value whose fraction LSB is 0.
- R6: `rnd_mode` 01 (toward zero) and 11 (toward minus infinity) truncate the discarded bits.
- R7: `rnd_mode` 10 (toward plus infinity) adds one to the packed exponent-and-fraction value whenever any discarded bit is nonzero.
- R8: A rounding increment that carries out of the fraction field raises the exponent by one and leaves a zero fraction, which gives the next power of two.
- R9: On an inexact conversion with `trap_en` high, the rounded result is delivered, `exc_code` is 01 and the sticky flag is unchanged. With `trap_en` low, `exc_code` is 00 and `inexact_flag` is set. The flag is cleared only by reset.
- R10: A single-precision result occupies `res[31:0]`, and `res[63:32]` is zero.
- R11: `done` is high for exactly the cycle after an accepted request and low otherwise. `req_ready` is always high. After reset `done`, `res`, `exc_code` and `inexact_flag` are all zero.
- R12: When the 32-bit source width is selected (`src_wide` low), `op_a[63:32]` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Request acceptance, constantly high |
| op_a | input | 64 | Unsigned source operand |
| src_wide | input | 1 | 1: 64-bit source, 0: 32-bit source in op_a[31:0] |
| dst_double | input | 1 | 1: double-precision result, 0: single precision |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| trap_en | input | 1 | 1: report inexact through exc_code, 0: through the sticky flag |
| res | output | 64 | Converted value, registered |
| done | output | 1 | One-cycle pulse marking a new result |
| exc_code | output | 2 | 00 no exception, 01 inexact |
| inexact_flag | output | 1 | Sticky inexact flag |

## Verification
The assertions check the control-level rules on every cycle:
- the done pulse follows each request by one cycle;
- zero sources give +0;
- a 32-bit to double conversion never reports inexact;
- a single-precision result leaves the upper half of the bus clear;
- a trapped request leaves the sticky flag alone, and the flag never drops outside reset.

Only the bench scenarios can show that the numeric value is correct in each rounding mode. This covers ties to even, the carry into the exponent, the offset path for a zero upper word, and ignoring the upper operand word on 32-bit requests. The bench compares these against its own arithmetic model.

// File: rtl/uifp_pkg.sv
// Package: shared widths, format constants and encodings for the
// unsigned-integer to floating-point converter.
package uifp_pkg;
    localparam int SRC_W     = 64;
    localparam int NARROW_W  = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_BIAS   = 127;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int DP_BIAS   = 1023;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_ZERO    = 2'b01,
        RND_PLUS    = 2'b10,
        RND_MINUS   = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'b00,
        EXC_INEXACT = 2'b01
    } exc_code_e;
endpackage

// File: rtl/uifp_lead_one.sv
// Module: uifp_lead_one
// Finds the index of the most significant set bit of a vector.
// Assumes: a zero vector is flagged by all_zero; pos is then 0 and
// must not be used.
module uifp_lead_one #(
    parameter int W = 64,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          all_zero
);
    // Scan upward so that the highest set bit writes pos last.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = PW'(i);
        end
    end

    // Zero detect for the caller's special case.
    assign all_zero = (vec == '0);
endmodule

// File: rtl/uifp_normalize.sv
// Module: uifp_normalize
// Left-aligns the source so that its leading one would sit in the MSB,
// then drops that bit (the hidden bit), so the returned W-1 bits are the
// fraction followed by the rounding remainder.
// Assumes: pos is the index of the leading one of a nonzero vec.
module uifp_normalize #(
    parameter int W = 64,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    input  logic [PW-1:0] pos,
    output logic [W-2:0]  below
);
    logic [PW-1:0] shamt;

    // Shift distance that moves the leading one to bit W-1.
    assign shamt = PW'(W - 1) - pos;

    // Aligned value with the hidden bit truncated away.
    assign below = (W-1)'(vec << shamt);
endmodule

// File: rtl/uifp_round_pack.sv
// Module: uifp_round_pack
// Builds one floating-point format from the normalized bits: selects the
// fraction, derives guard and sticky from the remainder, applies the
// rounding rule and packs exponent and fraction (sign omitted, always 0).
// Assumes: W-1 > FRAC_W + 1 so that at least guard and one sticky bit exist;
// the biased exponent cannot overflow for the given source width.
module uifp_round_pack
    import uifp_pkg::*;
#(
    parameter int W      = 64,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int BIAS   = 127,
    localparam int PW    = $clog2(W),
    localparam int REM_W = W - 1 - FRAC_W,
    localparam int PK_W  = EXP_W + FRAC_W
) (
    input  logic [W-2:0]  below,
    input  logic [PW-1:0] pos,
    input  logic [1:0]    mode,
    output logic [PK_W-1:0] packed_val,
    output logic          inexact
);
    logic [FRAC_W-1:0] frac;
    logic              guard_bit;
    logic              sticky_bit;
    logic [EXP_W-1:0]  exp_biased;
    logic              round_up;

    // Split the normalized bits into fraction, guard and sticky.
    assign frac       = below[W-2 -: FRAC_W];
    assign guard_bit  = below[REM_W-1];
    assign sticky_bit = |below[REM_W-2:0];

    // Biased exponent from the leading-one index.
    assign exp_biased = EXP_W'(pos) + EXP_W'(BIAS);

    // Any discarded bit makes the result inexact.
    assign inexact = guard_bit | sticky_bit;

    // Rounding decision per mode; source is never negative.
    always_comb begin
        case (mode)
            RND_NEAREST: round_up = guard_bit & (sticky_bit | frac[0]);
            RND_PLUS:    round_up = guard_bit | sticky_bit;
            default:     round_up = 1'b0;
        endcase
    end

    // Increment on the packed word so a fraction carry bumps the exponent.
    assign packed_val = {exp_biased, frac} + PK_W'(round_up);
endmodule

// File: rtl/uint_to_fp_conv.sv
// Module: uint_to_fp_conv (top)
// Converts an unsigned 32- or 64-bit integer to single or double precision
// in one registered stage. Reports inexact as an exception code (trap
// enabled) or through a sticky flag (trap disabled).
// Assumes: synchronous active-low reset; a request is taken in every cycle
// req_valid is high.
module uint_to_fp_conv
    import uifp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] op_a,
    input  logic        src_wide,
    input  logic        dst_double,
    input  logic [1:0]  rnd_mode,
    input  logic        trap_en,
    output logic [63:0] res,
    output logic        done,
    output logic [1:0]  exc_code,
    output logic        inexact_flag
);
    localparam int PW    = $clog2(SRC_W);
    localparam int SP_PK = SP_EXP_W + SP_FRAC_W;
    localparam int DP_PK = DP_EXP_W + DP_FRAC_W;

    logic [SRC_W-1:0] src_val;
    logic [PW-1:0]    lead_pos;
    logic             src_zero;
    logic [SRC_W-2:0] norm_bits;
    logic [SP_PK-1:0] sp_packed;
    logic [DP_PK-1:0] dp_packed;
    logic             sp_inexact;
    logic             dp_inexact;
    logic [63:0]      res_next;
    logic             inexact_next;

    // The unit never stalls.
    assign req_ready = 1'b1;

    // Zero-extend a narrow source, ignoring the upper operand word.
    assign src_val = src_wide ? op_a : {{(SRC_W-NARROW_W){1'b0}}, op_a[NARROW_W-1:0]};

    uifp_lead_one #(.W(SRC_W)) u_lead (
        .vec(src_val), .pos(lead_pos), .all_zero(src_zero)
    );

    uifp_normalize #(.W(SRC_W)) u_norm (
        .vec(src_val), .pos(lead_pos), .below(norm_bits)
    );

    uifp_round_pack #(.W(SRC_W), .EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W), .BIAS(SP_BIAS)) u_sp (
        .below(norm_bits), .pos(lead_pos), .mode(rnd_mode),
        .packed_val(sp_packed), .inexact(sp_inexact)
    );

    uifp_round_pack #(.W(SRC_W), .EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W), .BIAS(DP_BIAS)) u_dp (
        .below(norm_bits), .pos(lead_pos), .mode(rnd_mode),
        .packed_val(dp_packed), .inexact(dp_inexact)
    );

    // Select the requested format and handle the zero source.
    always_comb begin
        if (src_zero) begin
            res_next     = '0;
            inexact_next = 1'b0;
        end else if (dst_double) begin
            res_next     = {{(64-DP_PK){1'b0}}, dp_packed};
            inexact_next = dp_inexact;
        end else begin
            res_next     = {{(64-SP_PK){1'b0}}, sp_packed};
            inexact_next = sp_inexact;
        end
    end

    // Output register, done pulse, exception code and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res          <= '0;
            done         <= 1'b0;
            exc_code     <= EXC_NONE;
            inexact_flag <= 1'b0;
        end else begin
            done <= req_valid & req_ready;
            if (req_valid && req_ready) begin
                res      <= res_next;
                exc_code <= (inexact_next && trap_en) ? EXC_INEXACT : EXC_NONE;
                if (inexact_next && !trap_en) inexact_flag <= 1'b1;
            end
        end
    end

    // ---------------- assertions ----------------
    p_zero_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (src_wide ? (op_a == 64'd0) : (op_a[31:0] == 32'd0)))
        |=> (res == 64'd0 && exc_code == EXC_NONE && inexact_flag == $past(inexact_flag)));

    p_narrow_to_double_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !src_wide && dst_double)
        |=> (exc_code == EXC_NONE && inexact_flag == $past(inexact_flag)));

    p_trap_keeps_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && trap_en) |=> (inexact_flag == $past(inexact_flag)));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inexact_flag) |-> inexact_flag);

    p_single_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dst_double) |=> (res[63:32] == 32'd0));

    p_done_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);
endmodule

// File: tb/uint_to_fp_conv_bench.sv
// Bench: behavioural arithmetic model compared with the design each cycle.
module uint_to_fp_conv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] op_a = '0;
    logic        src_wide = 1'b0;
    logic        dst_double = 1'b0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        trap_en = 1'b0;
    logic [63:0] res;
    logic        done;
    logic [1:0]  exc_code;
    logic        inexact_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic exp_flag = 1'b0;
    logic [63:0] seed = 64'h9E3779B97F4A7C15;

    always #10 clk = ~clk;

    uint_to_fp_conv u_uint_to_fp_conv (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .op_a(op_a), .src_wide(src_wide), .dst_double(dst_double),
        .rnd_mode(rnd_mode), .trap_en(trap_en), .res(res), .done(done),
        .exc_code(exc_code), .inexact_flag(inexact_flag)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Arithmetic model: divide down to the fraction width, compare remainder.
    function automatic void model(input logic [63:0] a, input logic wide,
                                  input logic dbl, input logic [1:0] mode,
                                  output logic [63:0] r, output logic inex);
        logic [63:0] v, m, rem, half;
        int p, fw, bias, sh, e;
        logic up;
        v = wide ? a : {32'd0, a[31:0]};
        r = 64'd0; inex = 1'b0;
        if (v == 64'd0) return;
        p = 0;
        for (int i = 0; i < 64; i++) if (v[i]) p = i;
        fw   = dbl ? 52 : 23;
        bias = dbl ? 1023 : 127;
        rem = 64'd0; half = 64'd0;
        if (p <= fw) begin
            m = v << (fw - p);
        end else begin
            sh   = p - fw;
            m    = v >> sh;
            rem  = v & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
        end
        inex = (rem != 64'd0);
        case (mode)
            2'b00:   up = (rem > half) || (rem == half && rem != 64'd0 && m[0]);
            2'b10:   up = inex;
            default: up = 1'b0;
        endcase
        m = m + {63'd0, up};
        e = p + bias;
        if (m == (64'd1 << (fw + 1))) begin
            m = m >> 1;
            e = e + 1;
        end
        m = m & ~(64'd1 << fw);
        if (dbl) r = {1'b0, e[10:0], m[51:0]};
        else     r = {33'd0, e[7:0], m[22:0]};
    endfunction

    // One request: drive at a falling edge, check at the next falling edge.
    task automatic do_op(input string tag, input logic [63:0] a, input logic wide,
                         input logic dbl, input logic [1:0] mode, input logic trap);
        logic [63:0] er;
        logic ei;
        model(a, wide, dbl, mode, er, ei);
        op_a = a; src_wide = wide; dst_double = dbl; rnd_mode = mode; trap_en = trap;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (ei && !trap) exp_flag = 1'b1;
        check(tag, "res", res, er);
        check(tag, "exc_code", {62'd0, exc_code}, (ei && trap) ? 64'd1 : 64'd0);
        check(tag, "inexact_flag", {63'd0, inexact_flag}, {63'd0, exp_flag});
        check("R11", "done", {63'd0, done}, 64'd1);
        @(negedge clk);
        check("R11", "done idle", {63'd0, done}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "reset done", {63'd0, done}, 64'd0);
        check("R11", "reset res", res, 64'd0);
        check("R11", "reset exc", {62'd0, exc_code}, 64'd0);
        check("R11", "reset flag", {63'd0, inexact_flag}, 64'd0);
        check("R11", "ready", {63'd0, req_ready}, 64'd1);

        do_op("R1", 64'd0, 1'b0, 1'b0, 2'b00, 1'b0);
        do_op("R1", 64'd0, 1'b1, 1'b1, 2'b10, 1'b0);
        do_op("R2", 64'd1, 1'b0, 1'b0, 2'b00, 1'b0);
        do_op("R2", 64'h8000_0000_0000_0000, 1'b1, 1'b1, 2'b00, 1'b0);
        do_op("R3", 64'h0000_0000_8000_0001, 1'b1, 1'b1, 2'b00, 1'b0);
        do_op("R3", 64'h0000_0000_1234_5678, 1'b1, 1'b0, 2'b01, 1'b1);
        do_op("R4", 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1, 2'b10, 1'b1);
        do_op("R4", 64'h0000_0000_8765_4321, 1'b0, 1'b1, 2'b00, 1'b0);
        do_op("R5", 64'h0000_0000_0100_0001, 1'b0, 1'b0, 2'b00, 1'b1);
        do_op("R5", 64'h0000_0000_0100_0003, 1'b0, 1'b0, 2'b00, 1'b1);
        do_op("R6", 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 2'b01, 1'b1);
        do_op("R6", 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 2'b11, 1'b1);
        do_op("R7", 64'h0000_0000_0100_0001, 1'b0, 1'b0, 2'b10, 1'b1);
        do_op("R8", 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 2'b00, 1'b1);
        do_op("R8", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 2'b10, 1'b1);
        do_op("R10", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 2'b00, 1'b1);
        do_op("R12", 64'hDEAD_BEEF_0000_0005, 1'b0, 1'b0, 2'b00, 1'b1);
        do_op("R12", 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 2'b00, 1'b1);
        // Inexact with trap: code 01, flag still clear; then without trap.
        do_op("R9", 64'h0000_0000_0100_0001, 1'b0, 1'b0, 2'b01, 1'b1);
        do_op("R9", 64'h0000_0000_0100_0001, 1'b0, 1'b0, 2'b01, 1'b0);
        do_op("R9", 64'd7, 1'b0, 1'b0, 2'b00, 1'b0);

        // Mixed operand patterns over all size pairings and modes.
        for (int k = 0; k < 60; k++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 7);
            seed = seed ^ (seed << 17);
            do_op("R3", seed >> seed[5:0], seed[60], seed[61], seed[63:62], seed[59]);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule